// File: doc/BRIEF.md
# Data Address Translation Fault Checker

This block sits at the front of the data-side translation path. Each cycle it takes one load or store request: the virtual address, an access size code, the direction, a physical-mode flag and an alternate-mode flag. It also takes the current and alternate privilege modes, the superpage enables, and the result of a TLB lookup that was made elsewhere. The lookup result is a hit flag, a page number, read and write enables for each mode, and fault-on-read and fault-on-write bits. One clock later the block presents one of two results. The first is a physical address with a cacheable or uncacheable mark. The second is a fault code with a vector of memory-management status flags.

The checks are applied in a fixed priority order:
1. misalignment;
2. physical bypass;
3. superpage window, with its privilege test;
4. TLB miss;
5. per-mode permission;
6. fault-on bits;
7. implemented physical range.

A surviving address whose uncached bit is set has a fixed field cleared before it leaves the block. The TLB array and the handling of faults belong to other blocks.

Encodings used throughout:
- Fault codes: 0 none, 1 alignment, 2 access violation, 3 page fault, 4 TLB miss, 5 machine check.
- Status bits: bit 0 write, bit 1 access violation, bit 2 fault-on-read, bit 3 fault-on-write, bit 4 TLB miss.
- Privilege modes: 0 is kernel. The per-mode enables are indexed by mode number.
- Size code s: the access is 2^s bytes wide.

Top module: `dxlat_check`

## Requirements
- R1: When va AND (2^size-1) is nonzero, the fault is 1 (alignment), whatever the other inputs. The status is then only bit 0, set equal to write.
- R2: With the physical flag set, the raw physical address equals the virtual address, and the TLB inputs and the superpage decode have no effect.
- R3: The superpage window is entered in either of two cases: superpage-enable bit 1 is set and va[42:41]==2, or va[47:41]==0x7E. Inside the window the TLB inputs have no effect. The raw address is va[43:0], forced to ones in bits 43:40 if va[40] is set, and otherwise zeroed above bit 39.
- R4: A superpage access with a current mode other than 0 gives fault 2, with status bit 1 set and bit 0 equal to write. The alternate mode is not consulted for this test.
- R5: A non-bypassed, non-superpage access without a TLB hit gives fault 4, with status bit 4 set and bit 0 equal to write.
- R6: The effective mode is alt_mode when the alternate flag is set, and cur_mode otherwise. A store whose write enable bit for that mode is clear gives fault 3, with status bits 0 and 1 set and bit 3 equal to the fault-on-write bit. A load whose read enable bit is clear gives fault 2, with status bit 1 set and bit 2 equal to the fault-on-read bit.
- R7: A permitted store with fault-on-write set gives fault 3 with status bits 0 and 3. A permitted load with fault-on-read set gives fault 3 with status bit 2 only.
- R8: On a permitted TLB hit, the raw address is the page number shifted left by 13, ORed with va[12:0].
- R9: A raw address with any bit set at position 44 or above, and no earlier fault, gives fault 5 with all status bits clear.
- R10: A surviving address with bit 39 or bit 43 set is marked uncacheable, and bits 42:35 are cleared in the address output. Otherwise the address leaves unchanged and is marked cacheable.
- R11: Outputs are registered. They show the result for the inputs of the previous clock, and all are zero after reset. Whenever a fault is reported, the address output and the uncacheable mark are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| va_i | input | VA_W | Virtual address |
| size_i | input | 2 | Access size code, 2^size bytes |
| write_i | input | 1 | 1 for a store |
| phys_i | input | 1 | Physical-mode bypass |
| alt_i | input | 1 | Use the alternate mode for permission checks |
| cur_mode_i | input | MODE_W | Current privilege mode |
| alt_mode_i | input | MODE_W | Alternate privilege mode |
| spage_en_i | input | 2 | Superpage enables (bit 1 used) |
| tlb_hit_i | input | 1 | TLB lookup hit |
| tlb_ppn_i | input | PPN_W | Physical page number from the TLB |
| tlb_rd_en_i | input | 2^MODE_W | Read enable per mode |
| tlb_wr_en_i | input | 2^MODE_W | Write enable per mode |
| tlb_fonr_i | input | 1 | Fault-on-read bit |
| tlb_fonw_i | input | 1 | Fault-on-write bit |
| pa_o | output | 44 | Physical address |
| uncache_o | output | 1 | Uncacheable mark |
| fault_o | output | 3 | Fault code |
| status_o | output | 5 | Status flags |

## Verification
The bench builds the block with its default parameters:
- a 64-bit virtual address, so the high address bits and both superpage windows can be driven;
- a 32-bit page number, so its top bit shifted by 13 lands at bit 44, and an otherwise clean hit can raise the machine check;
- four privilege modes, so the alternate-mode selection indexes distinct enable bits.

The random stimulus steers addresses into both superpage windows, into small physical addresses, and into fully random values. This reaches every fault and each uncached bit, both on its own and in combination with the others.

// File: rtl/dxl_pkg.sv
package dxl_pkg;
  localparam int PA_BITS = 44;
  localparam int ST_W    = 5;
  localparam int ST_WR   = 0;
  localparam int ST_ACV  = 1;
  localparam int ST_FONR = 2;
  localparam int ST_FONW = 3;
  localparam int ST_MISS = 4;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_ALIGN = 3'd1,
    FLT_ACV   = 3'd2,
    FLT_PAGE  = 3'd3,
    FLT_DMISS = 3'd4,
    FLT_MCHK  = 3'd5
  } flt_e;

  // Superpage result: keep 40 bits, replicate bit 40 into 43:40.
  function automatic logic [PA_BITS-1:0] sext_super(input logic [PA_BITS-1:0] a);
    return {{4{a[40]}}, a[39:0]};
  endfunction

  function automatic logic is_uncached(input logic [PA_BITS-1:0] a);
    return a[43] | a[39];
  endfunction

  function automatic logic [PA_BITS-1:0] strip_uncached(input logic [PA_BITS-1:0] a);
    logic [PA_BITS-1:0] r;
    r = a;
    r[42:35] = '0;
    return r;
  endfunction
endpackage

// File: rtl/dxl_align_chk.sv
module dxl_align_chk (
  input  logic [2:0] va_lo,
  input  logic [1:0] size,
  output logic       misalign
);
  logic [2:0] bad_bit;
  for (genvar b = 0; b < 3; b++) begin : g_bit
    assign bad_bit[b] = va_lo[b] & (size > 2'(b));
  end
  assign misalign = |bad_bit;
endmodule

// File: rtl/dxl_spage_dec.sv
module dxl_spage_dec #(
  parameter int VA_W = 64
) (
  input  logic [VA_W-1:0] va,
  input  logic            en_win,
  output logic            in_window
);
  logic win_a, win_b;
  assign win_a = en_win & (va[42:41] == 2'b10);
  assign win_b = (va[47:41] == 7'h7E);
  assign in_window = win_a | win_b;
endmodule

// File: rtl/dxl_tlb_perm.sv
module dxl_tlb_perm
  import dxl_pkg::*;
#(
  parameter int MODE_W = 2,
  localparam int NMODES = 1 << MODE_W
) (
  input  logic              write,
  input  logic [MODE_W-1:0] mode,
  input  logic [NMODES-1:0] rd_en,
  input  logic [NMODES-1:0] wr_en,
  input  logic              fonr,
  input  logic              fonw,
  output flt_e              flt,
  output logic [ST_W-1:0]   st
);
  logic [NMODES-1:0] mask;
  assign mask = NMODES'(1) << mode;

  always_comb begin
    flt = FLT_NONE;
    st  = '0;
    if (write) begin
      if ((wr_en & mask) == '0) begin
        flt = FLT_PAGE;
        st[ST_WR]   = 1'b1;
        st[ST_ACV]  = 1'b1;
        st[ST_FONW] = fonw;
      end else if (fonw) begin
        flt = FLT_PAGE;
        st[ST_WR]   = 1'b1;
        st[ST_FONW] = 1'b1;
      end
    end else begin
      if ((rd_en & mask) == '0) begin
        flt = FLT_ACV;
        st[ST_ACV]  = 1'b1;
        st[ST_FONR] = fonr;
      end else if (fonr) begin
        flt = FLT_PAGE;
        st[ST_FONR] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dxlat_check.sv
module dxlat_check
  import dxl_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int PPN_W     = 32,
  parameter int PAGE_BITS = 13,
  parameter int MODE_W    = 2,
  localparam int NMODES   = 1 << MODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VA_W-1:0]   va_i,
  input  logic [1:0]        size_i,
  input  logic              write_i,
  input  logic              phys_i,
  input  logic              alt_i,
  input  logic [MODE_W-1:0] cur_mode_i,
  input  logic [MODE_W-1:0] alt_mode_i,
  input  logic [1:0]        spage_en_i,
  input  logic              tlb_hit_i,
  input  logic [PPN_W-1:0]  tlb_ppn_i,
  input  logic [NMODES-1:0] tlb_rd_en_i,
  input  logic [NMODES-1:0] tlb_wr_en_i,
  input  logic              tlb_fonr_i,
  input  logic              tlb_fonw_i,
  output logic [PA_BITS-1:0] pa_o,
  output logic              uncache_o,
  output logic [2:0]        fault_o,
  output logic [ST_W-1:0]   status_o
);
  function automatic logic [VA_W-1:0] page_join(input logic [PPN_W-1:0] ppn,
                                                input logic [VA_W-1:0] va);
    logic [VA_W-1:0] off;
    off = '0;
    off[PAGE_BITS-1:0] = va[PAGE_BITS-1:0];
    return (VA_W'(ppn) << PAGE_BITS) | off;
  endfunction

  logic              misalign_w;
  logic              spage_w;
  logic [MODE_W-1:0] eff_mode_w;
  flt_e              perm_flt_w;
  logic [ST_W-1:0]   perm_st_w;
  logic [VA_W-1:0]   raw_w;
  flt_e              flt_w;
  logic [ST_W-1:0]   st_w;
  logic              out_range_w;
  logic [PA_BITS-1:0] pa_n;
  logic              unc_n;

  dxl_align_chk u_align (
    .va_lo    (va_i[2:0]),
    .size     (size_i),
    .misalign (misalign_w)
  );

  dxl_spage_dec #(.VA_W(VA_W)) u_spage (
    .va        (va_i),
    .en_win    (spage_en_i[1]),
    .in_window (spage_w)
  );

  assign eff_mode_w = alt_i ? alt_mode_i : cur_mode_i;

  dxl_tlb_perm #(.MODE_W(MODE_W)) u_perm (
    .write (write_i),
    .mode  (eff_mode_w),
    .rd_en (tlb_rd_en_i),
    .wr_en (tlb_wr_en_i),
    .fonr  (tlb_fonr_i),
    .fonw  (tlb_fonw_i),
    .flt   (perm_flt_w),
    .st    (perm_st_w)
  );

  always_comb begin
    flt_w = FLT_NONE;
    st_w  = '0;
    raw_w = '0;
    if (misalign_w) begin
      flt_w = FLT_ALIGN;
      st_w[ST_WR] = write_i;
    end else if (phys_i) begin
      raw_w = va_i;
    end else if (spage_w) begin
      raw_w = VA_W'(sext_super(va_i[PA_BITS-1:0]));
      if (cur_mode_i != '0) begin
        flt_w = FLT_ACV;
        st_w[ST_WR]  = write_i;
        st_w[ST_ACV] = 1'b1;
      end
    end else if (!tlb_hit_i) begin
      flt_w = FLT_DMISS;
      st_w[ST_WR]   = write_i;
      st_w[ST_MISS] = 1'b1;
    end else begin
      raw_w = page_join(tlb_ppn_i, va_i);
      if (perm_flt_w != FLT_NONE) begin
        flt_w = perm_flt_w;
        st_w  = perm_st_w;
      end
    end
    if (flt_w == FLT_NONE && out_range_w) begin
      flt_w = FLT_MCHK;
      st_w  = '0;
    end
  end

  assign out_range_w = |raw_w[VA_W-1:PA_BITS];

  always_comb begin
    pa_n  = '0;
    unc_n = 1'b0;
    if (flt_w == FLT_NONE) begin
      unc_n = is_uncached(raw_w[PA_BITS-1:0]);
      pa_n  = unc_n ? strip_uncached(raw_w[PA_BITS-1:0]) : raw_w[PA_BITS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_o      <= '0;
      uncache_o <= 1'b0;
      fault_o   <= '0;
      status_o  <= '0;
    end else begin
      pa_o      <= pa_n;
      uncache_o <= unc_n;
      fault_o   <= flt_w;
      status_o  <= st_w;
    end
  end
endmodule

// File: rtl/dxlat_check_sva.sv
module dxlat_check_sva
  import dxl_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               write_i,
  input logic               phys_i,
  input logic               tlb_hit_i,
  input logic               misalign_w,
  input logic               spage_w,
  input logic [PA_BITS-1:0] pa_o,
  input logic               uncache_o,
  input logic [2:0]         fault_o,
  input logic [ST_W-1:0]    status_o
);
  p_align_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_w |=> (fault_o == FLT_ALIGN) && (status_o == {4'b0, $past(write_i)}));

  p_phys_no_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!misalign_w && phys_i) |=> (fault_o != FLT_DMISS) && (fault_o != FLT_PAGE));

  p_spage_no_tlb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!misalign_w && !phys_i && spage_w) |=> (fault_o != FLT_DMISS) && (fault_o != FLT_PAGE));

  p_miss_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!misalign_w && !phys_i && !spage_w && !tlb_hit_i) |=>
      (fault_o == FLT_DMISS) && status_o[ST_MISS]);

  p_mchk_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o == FLT_MCHK) |-> (status_o == '0));

  p_strip_field_r10: assert property (@(posedge clk) disable iff (!rst_n)
    uncache_o |-> (pa_o[42:35] == 8'h00));

  p_fault_zero_pa_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o != FLT_NONE) |-> ((pa_o == '0) && !uncache_o));
endmodule

bind dxlat_check dxlat_check_sva u_sva (.*);

// File: tb/tb_dxlat_check.sv
module tb_dxlat_check;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] va = '0;
  logic [1:0]  sz = '0;
  logic        wr = 1'b0, phys = 1'b0, alt = 1'b0;
  logic [1:0]  cm = '0, am = '0, spen = '0;
  logic        hit = 1'b0;
  logic [31:0] ppn = '0;
  logic [3:0]  ren = '0, wen = '0;
  logic        fonr = 1'b0, fonw = 1'b0;
  logic [43:0] pa_o;
  logic        unc_o;
  logic [2:0]  flt_o;
  logic [4:0]  st_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dxlat_check dut (
    .clk(clk), .rst_n(rst_n), .va_i(va), .size_i(sz), .write_i(wr),
    .phys_i(phys), .alt_i(alt), .cur_mode_i(cm), .alt_mode_i(am),
    .spage_en_i(spen), .tlb_hit_i(hit), .tlb_ppn_i(ppn),
    .tlb_rd_en_i(ren), .tlb_wr_en_i(wen), .tlb_fonr_i(fonr),
    .tlb_fonw_i(fonw), .pa_o(pa_o), .uncache_o(unc_o),
    .fault_o(flt_o), .status_o(st_o)
  );

  typedef struct packed {
    logic [2:0]  f;
    logic [4:0]  s;
    logic [43:0] pa;
    logic        u;
  } exp_t;

  function automatic exp_t model();
    exp_t e;
    logic [63:0] raw;
    logic [3:0]  mm;
    e = '0;
    if ((va & ((64'd1 << sz) - 64'd1)) != 0) begin
      e.f = 3'd1; e.s = {4'b0, wr}; return e;
    end
    if (phys) raw = va;
    else if ((spen[1] && va[42:41] == 2'b10) || va[47:41] == 7'h7E) begin
      if (cm != 2'd0) begin e.f = 3'd2; e.s = {3'b0, 1'b1, wr}; return e; end
      raw = {20'b0, (va[40] ? 4'hF : 4'h0), va[39:0]};
    end else if (!hit) begin
      e.f = 3'd4; e.s = {1'b1, 3'b0, wr}; return e;
    end else begin
      raw = {19'b0, ppn, va[12:0]};
      mm = 4'b0001 << (alt ? am : cm);
      if (wr) begin
        if ((wen & mm) == 0) begin e.f = 3'd3; e.s = {1'b0, fonw, 1'b0, 2'b11}; return e; end
        if (fonw) begin e.f = 3'd3; e.s = 5'b01001; return e; end
      end else begin
        if ((ren & mm) == 0) begin e.f = 3'd2; e.s = {2'b0, fonr, 2'b10}; return e; end
        if (fonr) begin e.f = 3'd3; e.s = 5'b00100; return e; end
      end
    end
    if (raw[63:44] != 0) begin e.f = 3'd5; return e; end
    e.u  = raw[43] | raw[39];
    e.pa = e.u ? (raw[43:0] & ~44'h7F8_0000_0000) : raw[43:0];
    return e;
  endfunction

  task automatic run(input string tag);
    exp_t e;
    e = model();
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (flt_o !== e.f || st_o !== e.s || pa_o !== e.pa || unc_o !== e.u) begin
      errors++;
      $display("FAIL %s: got f=%0d s=%b pa=%h u=%b exp f=%0d s=%b pa=%h u=%b",
               tag, flt_o, st_o, pa_o, unc_o, e.f, e.s, e.pa, e.u);
    end
  endtask

  task automatic base();
    va = '0; sz = 2'd0; wr = 0; phys = 0; alt = 0; cm = 0; am = 0;
    spen = 2'b00; hit = 1; ppn = 32'h0000_1234; ren = 4'hF; wen = 4'hF;
    fonr = 0; fonw = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got running exp finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    base();
    repeat (3) @(negedge clk);
    checks++;
    if (pa_o !== '0 || unc_o !== 0 || flt_o !== 0 || st_o !== 0) begin
      errors++;
      $display("FAIL R11 reset: got f=%0d s=%b pa=%h exp zeros", flt_o, st_o, pa_o);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1: misaligned store, beats physical mode and TLB miss
    base(); va = 64'h6; sz = 2'd2; wr = 1; phys = 1; hit = 0; run("R1 align store");
    base(); va = 64'h1; sz = 2'd1; run("R1 align load");
    base(); va = 64'h4; sz = 2'd2; run("R1 aligned word");
    // R2: bypass ignores a TLB miss
    base(); va = 64'h0000_0012_3456_7000; phys = 1; hit = 0; run("R2 physical");
    // R3: both windows, with and without bit 40
    base(); va = 64'h0000_FD00_0000_2000; hit = 0; run("R3 window 7E");
    base(); va = 64'h0000_0500_0000_0010; spen = 2'b10; hit = 0; run("R3 window 42:41 bit40");
    base(); va = 64'h0000_0400_1234_0008; spen = 2'b01; hit = 1; run("R3 enable bit0 only");
    // R4: superpage outside kernel, alternate kernel does not help
    base(); va = 64'h0000_FC00_0000_0000; cm = 2'd3; alt = 1; am = 0; wr = 1; run("R4 super user");
    // R5
    base(); hit = 0; wr = 1; va = 64'h2000; run("R5 miss store");
    // R6: alternate mode selects enable bit
    base(); alt = 1; am = 2'd2; cm = 2'd0; wen = 4'b1011; wr = 1; fonw = 1; run("R6 write deny alt");
    base(); cm = 2'd1; ren = 4'b1101; fonr = 1; run("R6 read deny");
    base(); alt = 1; am = 2'd0; cm = 2'd3; ren = 4'b0001; run("R6 alt grants");
    // R7
    base(); wr = 1; fonw = 1; run("R7 fonw");
    base(); fonr = 1; fonw = 1; run("R7 fonr load");
    // R8
    base(); ppn = 32'h0ABC_DEF1; va = 64'h1FF8; sz = 2'd3; run("R8 page join");
    // R9
    base(); ppn = 32'h8000_0000; run("R9 ppn range");
    base(); phys = 1; va = 64'h0000_1000_0000_0000; run("R9 phys range");
    // R10
    base(); phys = 1; va = 64'h0000_0FFF_FFFF_FFF8; run("R10 both uncached");
    base(); phys = 1; va = 64'h0000_00C0_0000_0000; run("R10 bit39");

    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom % 5;
      va = {$urandom, $urandom};
      if (r == 1) va[47:41] = 7'h7E;
      if (r == 2) begin va[42:41] = 2'b10; va[47:43] = 5'h00; end
      if (r == 3) va[63:44] = '0;
      if ($urandom % 10 < 7) va[2:0] = 3'b000;
      sz = 2'($urandom); wr = 1'($urandom); phys = ($urandom % 5 == 0);
      alt = 1'($urandom); cm = 2'($urandom); am = 2'($urandom);
      spen = 2'($urandom); hit = ($urandom % 4 != 0); ppn = $urandom;
      ren = 4'($urandom | 32'h1); wen = 4'($urandom);
      fonr = ($urandom % 5 == 0); fonw = ($urandom % 5 == 0);
      run("R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule